// File: doc/BRIEF.md
# Multi-flag FIFO with retransmit

A synchronous first-in first-out buffer of 2048 nine-bit words. A write strobe (active low) pushes the input word at a clock edge, and a read strobe (active low) pops the oldest word into a registered output. The output is paired with a drive-enable. That enable is active only while the read strobe is low and the output enable (also active low) is asserted. This models a tri-state bus as a value plus an enable. Two path selects must be high for the parallel write and read paths to act.

Seven status flags are decoded from a single occupancy count. Three mark the full side: full, one short of full, and almost full. Three mark the empty side: empty, one above empty, and almost empty. The seventh, half-full, appears on a shared pin that shows it only when the expansion input is low (single-device operation). A retransmit input rewinds reading to address 0 so that stored data can be read again.

Top module: `mflag_fifo`

## Requirements
- R1: With `wr_n` low, `par_in` high, `rt` low and the FIFO not full, the word on `din` is stored at the clock edge. A write while full is ignored, and neither pointer moves.
- R2: With `rd_n` low, `par_out` high, `rt` low and the FIFO not empty, the oldest word appears on `dout` after the clock edge, in write order. A read while empty is ignored, and `dout` keeps its value.
- R3: With `par_in` low, the write strobe has no effect. With `par_out` low, the read strobe has no effect.
- R4: `dout_en` is high exactly when `rd_n` is low and `oe_n` is low. While `rd_n` is high it is low, whatever `oe_n` is.
- R5: `full` is high at a count of 2048 and `full_m1` at 2047. `empty` is high at a count of 0 and `empty_p1` at 1.
- R6: With `xi` low, `hf_xo` is high when the count is 1025 or more. With `xi` high, `hf_xo` is low.
- R7: `almost_full` is high at a count of 2040 or more. `almost_empty` is high at a count of 8 or less.
- R8: `rt` high at a clock edge sets the read pointer to 0 and sets the count to the write pointer value. Writes and reads in that cycle are ignored.
- R9: After reset both pointers are 0. `empty`, `almost_empty` and `dout_en`-independent flags show an empty FIFO: `empty` and `almost_empty` are high, and all other flags are low.
- R10: A read and a write in the same cycle on a FIFO that is neither empty nor full leave the count unchanged. On an empty FIFO only the write acts. On a full FIFO only the read acts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| par_in | input | 1 | Parallel write path select |
| par_out | input | 1 | Parallel read path select |
| xi | input | 1 | Expansion input; low selects single-device operation |
| rt | input | 1 | Retransmit |
| din | input | 9 | Write data |
| dout | output | 9 | Read data |
| dout_en | output | 1 | Bus drive enable for dout |
| full | output | 1 | Count equals depth |
| full_m1 | output | 1 | Count equals depth minus one |
| empty | output | 1 | Count is zero |
| empty_p1 | output | 1 | Count is one |
| hf_xo | output | 1 | Half-full in single-device operation |
| almost_full | output | 1 | Count at or above the almost-full level |
| almost_empty | output | 1 | Count at or below the almost-empty level |

## Verification
The bench drives the FIFO to full and then attempts a write. A design that let that write through would advance the write pointer and corrupt the oldest data, which shows up as a wrong word on a later read. The bench also walks the count across every flag threshold: 0, 1, 8, 9, 1024, 1025, 2039, 2040, 2047 and 2048. An off-by-one compare would move a flag one word early or late. It rewinds mid-stream with retransmit and reads back from word 0, which catches a rewind that keeps the old count or reads from the wrong address. It also sweeps read strobe against output enable, so a bus that drives with the strobe high is exposed.

// File: rtl/mflag_fifo.sv
module mflag_fifo #(
  parameter int W        = 9,
  parameter int DEPTH    = 2048,
  parameter int AF_GAP   = 8,
  parameter int AE_LEVEL = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_n,
  input  logic         rd_n,
  input  logic         oe_n,
  input  logic         par_in,
  input  logic         par_out,
  input  logic         xi,
  input  logic         rt,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dout_en,
  output logic         full,
  output logic         full_m1,
  output logic         empty,
  output logic         empty_p1,
  output logic         hf_xo,
  output logic         almost_full,
  output logic         almost_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic [W-1:0]  dout_q;

  wire we = !wr_n && par_in  && !rt && !full;
  wire re = !rd_n && par_out && !rt && !empty;

  assign full         = cnt == CW'(DEPTH);
  assign full_m1      = cnt == CW'(DEPTH - 1);
  assign empty        = cnt == '0;
  assign empty_p1     = cnt == CW'(1);
  assign hf_xo        = !xi && (cnt >= CW'(DEPTH / 2 + 1));
  assign almost_full  = cnt >= CW'(DEPTH - AF_GAP);
  assign almost_empty = cnt <= CW'(AE_LEVEL);
  assign dout_en      = !rd_n && !oe_n;
  assign dout         = dout_q;

  always_ff @(posedge clk)
    if (we) mem[wr_ptr] <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      dout_q <= '0;
    end else if (rt) begin
      rd_ptr <= '0;
      cnt    <= CW'(wr_ptr);
    end else begin
      if (we) wr_ptr <= wr_ptr + 1'b1;
      if (re) begin
        dout_q <= mem[rd_ptr];
        rd_ptr <= rd_ptr + 1'b1;
      end
      cnt <= cnt + CW'(we) - CW'(re);
    end
  end

  // R1
  full_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rt) |=> $stable(wr_ptr));
  // R2
  empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !rt) |=> ($stable(rd_ptr) && $stable(dout)));
  // R4
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> !dout_en);
  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full, full_m1, empty, empty_p1}));
  // R8
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt |=> (rd_ptr == '0 && cnt == CW'($past(wr_ptr))));
  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
endmodule

// File: tb/mflag_fifo_tb_top.sv
module mflag_fifo_tb_top;
  localparam int DEPTH = 2048;

  logic clk = 0, rst_n = 0;
  logic wr_n = 1, rd_n = 1, oe_n = 1, par_in = 1, par_out = 1, xi = 0, rt = 0;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic dout_en, full, full_m1, empty, empty_p1, hf_xo, almost_full, almost_empty;

  mflag_fifo dut_i (.clk, .rst_n, .wr_n, .rd_n, .oe_n, .par_in, .par_out, .xi, .rt,
    .din, .dout, .dout_en, .full, .full_m1, .empty, .empty_p1, .hf_xo,
    .almost_full, .almost_empty);

  always #2.5 clk = ~clk;

  int vec = 0, bad = 0;
  logic [8:0] bm [DEPTH];
  int bw = 0, br = 0, bc = 0;
  logic [8:0] exp_dout = '0;

  task automatic chk(string tag, int act, int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit e_hf(int c, bit x); return !x && c >= DEPTH/2 + 1; endfunction

  task automatic chk_flags();
    chk("R5 full",     full,     bc == DEPTH);
    chk("R5 full_m1",  full_m1,  bc == DEPTH - 1);
    chk("R5 empty",    empty,    bc == 0);
    chk("R5 empty_p1", empty_p1, bc == 1);
    chk("R6 hf_xo",    hf_xo,    e_hf(bc, xi));
    chk("R7 almost_full",  almost_full,  bc >= DEPTH - 8);
    chk("R7 almost_empty", almost_empty, bc <= 8);
  endtask

  task automatic step(bit w, bit r, bit o, bit [8:0] d, bit pi, bit po, bit x, bit t);
    bit dw, dr;
    wr_n = !w; rd_n = !r; oe_n = !o; din = d; par_in = pi; par_out = po; xi = x; rt = t;
    #1;
    chk("R4 dout_en", dout_en, r && o);
    dw = w && pi && !t && bc < DEPTH;
    dr = r && po && !t && bc > 0;
    @(posedge clk); #1;
    if (t) begin br = 0; bc = bw % DEPTH; end
    else begin
      if (dw) begin bm[bw % DEPTH] = d; bw++; end
      if (dr) begin exp_dout = bm[br % DEPTH]; br++; end
      bc = bc + int'(dw) - int'(dr);
    end
    chk("R2 dout", dout, exp_dout);
    chk_flags();
  endtask

  task automatic do_reset();
    rst_n = 0; wr_n = 1; rd_n = 1; oe_n = 1; rt = 0; xi = 0; par_in = 1; par_out = 1;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    bw = 0; br = 0; bc = 0; exp_dout = '0;
    // R9 reset state
    chk("R9 dout", dout, 0);
    chk("R9 empty", empty, 1);
    chk("R9 almost_empty", almost_empty, 1);
    chk("R9 others", {full, full_m1, empty_p1, hf_xo, almost_full}, 0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    #1;
    do_reset();
    // R1 R2 single word
    step(1, 0, 0, 9'h1a5, 1, 1, 0, 0);
    step(0, 1, 1, 0, 1, 1, 0, 0);
    // R2 read while empty ignored
    step(0, 1, 1, 0, 1, 1, 0, 0);
    // R10 read+write on empty: only write acts
    step(1, 1, 0, 9'h033, 1, 1, 0, 0);
    chk("R10 empty rw", empty_p1, 1);
    // R3 path selects low
    step(1, 0, 0, 9'h0ff, 0, 1, 0, 0);
    step(0, 1, 0, 0, 1, 0, 0, 0);
    chk("R3 count held", empty_p1, 1);
    // fill to full, crossing all thresholds (R5 R6 R7)
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 9'(i * 7 + 3), 1, 1, 0, 0);
    chk("R5 full reached", full, 1);
    // R1 write while full ignored
    step(1, 0, 0, 9'h1ff, 1, 1, 0, 0);
    // R6 xi high suppresses half-full
    step(0, 0, 0, 0, 1, 1, 1, 0);
    // R10 read+write while full: only read
    step(1, 1, 1, 9'h100, 1, 1, 0, 0);
    step(1, 1, 0, 9'h101, 1, 1, 0, 0);
    // R4 sweep
    step(0, 1, 0, 0, 1, 1, 0, 0);
    step(0, 0, 1, 0, 1, 1, 0, 0);
    step(0, 1, 1, 0, 1, 1, 0, 0);
    // drain
    for (int i = 0; i < DEPTH + 4; i++) step(0, 1, i[0], 0, 1, 1, 0, 0);
    // R8 retransmit without wrap
    do_reset();
    for (int i = 0; i < 100; i++) step(1, 0, 0, 9'(i + 40), 1, 1, 0, 0);
    for (int i = 0; i < 50; i++) step(0, 1, 1, 0, 1, 1, 0, 0);
    step(1, 1, 1, 9'h155, 1, 1, 0, 1);
    chk("R8 count after rewind", almost_empty, 0);
    step(0, 1, 1, 0, 1, 1, 0, 0);
    chk("R8 first word again", dout, 40);
    // random mix
    for (int i = 0; i < 6000; i++) begin
      int p = $urandom_range(0, 99);
      step(p < 55, $urandom_range(0, 99) < 45, $urandom_range(0, 1), 9'($urandom),
           $urandom_range(0, 15) != 0, $urandom_range(0, 15) != 0,
           $urandom_range(0, 9) == 0, $urandom_range(0, 199) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule